// File: doc/BRIEF.md
# Priority Task Flag Dispatcher

A shared hardware work queue that several processors poll for their next job. Each possible task is a single pending flag, and the flag's index is also its priority: a higher index is more urgent. Any port may post a task number, which raises that flag. A port that wants work raises a fetch request. When that request is granted, the block returns the highest pending index and clears that flag in the same access. Two processors therefore never receive the same task. A fetch that finds nothing pending returns a miss.

The block never pushes work to anyone; it only answers requests. Posts from every port are applied in parallel, because setting flags cannot conflict. Fetches are granted to one port per cycle by a round-robin arbiter, so each removal is atomic. A maintenance input raises every flag at once, and the full flag vector is always visible as a read-only snapshot.

Top module: `tfd_dispatch`

## Requirements
- R1: While `rst_n` is low, `pending` is all zeros and `rsp_valid` is low. Reset is asynchronous.
- R2: A post (`post_valid[p]` high, level on `post_level[p*4 +: 4]`) sets bit `level` of `pending` at the next rising edge. Posts from several ports in one cycle all take effect.
- R3: A granted fetch produces `rsp_valid` high one cycle later, with `rsp_hit` high and `rsp_level` equal to the highest set bit of `pending` at the grant cycle.
- R4: The level returned by a hit is cleared in `pending` at the same edge that presents the response.
- R5: A granted fetch with `pending` all zeros gives `rsp_hit` low and `rsp_level` zero, and leaves `pending` unchanged.
- R6: Posting a level that is already pending changes no bit of `pending`.
- R7: `set_all` high makes every bit of `pending` one at the next edge, whatever else happens in that cycle.
- R8: At most one bit of `fetch_gnt` is high in any cycle, and only for a port whose `fetch_req` is high.
- R9: Fetch grants rotate. After port k is granted, the search for the next grant starts at port k+1, wrapping. After reset, the search starts at port 0.
- R10: `rsp_port` gives the index of the port whose grant produced the response.
- R11: If a fetch and a post of the same level occur in one cycle, the fetch returns that level and the flag remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | NUM_PORTS | Per-port post strobe |
| post_level | input | NUM_PORTS*LW | Per-port task level, port p at bits p*LW +: LW |
| fetch_req | input | NUM_PORTS | Per-port fetch request, held until granted |
| fetch_gnt | output | NUM_PORTS | One-hot grant, same cycle as the request |
| set_all | input | 1 | Raise every pending flag |
| rsp_valid | output | 1 | Fetch response present |
| rsp_hit | output | 1 | Response carries a task |
| rsp_level | output | LW | Returned task level, zero on a miss |
| rsp_port | output | PW | Port that was granted |
| pending | output | NUM_LEVELS | Snapshot of all pending flags |

## Verification
The main function is tested with several kinds of traffic:
- Scattered posts drained by a single requester show that the highest level is picked and then removed.
- All ports requesting together, with the queue alternately loaded and empty, separate the rotation order from the hit/miss decision.
- Duplicate posts, a post colliding with a fetch of the same level, and a set-all issued alongside a fetch each exercise one merge rule of the flag update.
- A full drain after set-all walks every level in descending order and ends on a miss.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  localparam int unsigned TFD_DEF_PORTS  = 4;
  localparam int unsigned TFD_DEF_LEVELS = 16;
endpackage

// File: rtl/tfd_rr_arbiter.sv
module tfd_rr_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    logic        found;
    int unsigned idx;
    gnt    = '0;
    found  = 1'b0;
    ptr_d  = ptr_q;
    for (int unsigned k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        ptr_d    = IW'((idx + 1) % N);
      end
    end
    ptr_en = found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tfd_prio_enc.sv
module tfd_prio_enc #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]         vec,
  output logic                 any,
  output logic [$clog2(W)-1:0] top
);
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int unsigned i = 0; i < W; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        top = ($clog2(W))'(i);
      end
    end
  end
endmodule

// File: rtl/tfd_flag_bank.sv
module tfd_flag_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  input  logic         set_all,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q, flags_d;

  // clear first, then set: a same-cycle post wins over a fetch
  always_comb begin
    if (set_all) flags_d = '1;
    else         flags_d = (flags_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/tfd_dispatch.sv
module tfd_dispatch #(
  parameter int unsigned NUM_PORTS  = tfd_pkg::TFD_DEF_PORTS,
  parameter int unsigned NUM_LEVELS = tfd_pkg::TFD_DEF_LEVELS,
  localparam int unsigned LW = $clog2(NUM_LEVELS),
  localparam int unsigned PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PORTS-1:0]      post_valid,
  input  logic [NUM_PORTS*LW-1:0]   post_level,
  input  logic [NUM_PORTS-1:0]      fetch_req,
  output logic [NUM_PORTS-1:0]      fetch_gnt,
  input  logic                      set_all,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [LW-1:0]             rsp_level,
  output logic [PW-1:0]             rsp_port,
  output logic [NUM_LEVELS-1:0]     pending
);
  logic [NUM_LEVELS-1:0] port_mask [NUM_PORTS];
  logic [NUM_LEVELS-1:0] set_mask, clr_mask;
  logic                  enc_any;
  logic [LW-1:0]         enc_top;
  logic                  any_gnt;
  logic [PW-1:0]         gnt_idx;

  // per-port post decode
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_post
    always_comb begin
      port_mask[p] = '0;
      if (post_valid[p]) port_mask[p][post_level[p*LW +: LW]] = 1'b1;
    end
  end

  always_comb begin
    set_mask = '0;
    for (int unsigned p = 0; p < NUM_PORTS; p++) set_mask = set_mask | port_mask[p];
  end

  tfd_rr_arbiter #(.N(NUM_PORTS)) u_arb (
    .clk (clk),
    .rst_n (rst_n),
    .req (fetch_req),
    .gnt (fetch_gnt)
  );

  tfd_prio_enc #(.W(NUM_LEVELS)) u_enc (
    .vec (pending),
    .any (enc_any),
    .top (enc_top)
  );

  always_comb begin
    any_gnt = |fetch_gnt;
    gnt_idx = '0;
    for (int unsigned p = 0; p < NUM_PORTS; p++)
      if (fetch_gnt[p]) gnt_idx = PW'(p);
    clr_mask = '0;
    if (any_gnt && enc_any) clr_mask[enc_top] = 1'b1;
  end

  tfd_flag_bank #(.W(NUM_LEVELS)) u_bank (
    .clk (clk),
    .rst_n (rst_n),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .set_all (set_all),
    .flags (pending)
  );

  // response register
  logic          rv_q, rh_q, rh_d;
  logic [LW-1:0] rl_q, rl_d;
  logic [PW-1:0] rp_q;

  always_comb begin
    rh_d = enc_any;
    rl_d = enc_any ? enc_top : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= any_gnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rh_q <= 1'b0;
      rl_q <= '0;
      rp_q <= '0;
    end else if (any_gnt) begin
      rh_q <= rh_d;
      rl_q <= rl_d;
      rp_q <= gnt_idx;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_level = rl_q;
  assign rsp_port  = rp_q;
endmodule

// File: rtl/tfd_dispatch_chk.sv
module tfd_dispatch_chk #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned NUM_LEVELS = 16,
  localparam int unsigned LW = $clog2(NUM_LEVELS),
  localparam int unsigned PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_PORTS-1:0]    post_valid,
  input logic [NUM_PORTS*LW-1:0] post_level,
  input logic [NUM_PORTS-1:0]    fetch_req,
  input logic [NUM_PORTS-1:0]    fetch_gnt,
  input logic                    set_all,
  input logic                    rsp_valid,
  input logic                    rsp_hit,
  input logic [LW-1:0]           rsp_level,
  input logic [PW-1:0]           rsp_port,
  input logic [NUM_LEVELS-1:0]   pending
);
  logic [NUM_LEVELS-1:0] prev_pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_pend <= '0;
    else        prev_pend <= pending;
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fetch_gnt));
  // R8
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n) (fetch_gnt & ~fetch_req) == '0);
  // R3
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) (|fetch_gnt) |=> rsp_valid);
  // R3
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !(|fetch_gnt) |=> !rsp_valid);
  // R3
  hit_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ((prev_pend >> rsp_level) == NUM_LEVELS'(1)));
  // R5
  miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (prev_pend == '0 && rsp_level == '0));
  // R7
  set_all_chk: assert property (@(posedge clk) disable iff (!rst_n) set_all |=> (&pending));
  // R6
  keep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fetch_gnt) |=> ((pending & $past(pending)) == $past(pending)));
endmodule

bind tfd_dispatch tfd_dispatch_chk #(.NUM_PORTS(NUM_PORTS), .NUM_LEVELS(NUM_LEVELS)) u_chk (.*);

// File: tb/tfd_dispatch_tb.sv
module tfd_dispatch_tb;
  localparam int NP = 4;
  localparam int NL = 16;

  logic          clk;
  logic          rst_n;
  logic [3:0]    post_valid;
  logic [15:0]   post_level;
  logic [3:0]    fetch_req;
  logic [3:0]    fetch_gnt;
  logic          set_all;
  logic          rsp_valid, rsp_hit;
  logic [3:0]    rsp_level;
  logic [1:0]    rsp_port;
  logic [15:0]   pending;

  int checks = 0;
  int errors = 0;

  tfd_dispatch #(.NUM_PORTS(NP), .NUM_LEVELS(NL)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .post_valid (post_valid), .post_level (post_level),
    .fetch_req (fetch_req), .fetch_gnt (fetch_gnt),
    .set_all (set_all),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit),
    .rsp_level (rsp_level), .rsp_port (rsp_port),
    .pending (pending)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  pv;
    logic [15:0] plv;
    logic [3:0]  fr;
    logic        sa;
    logic [3:0]  eg;
    logic        ev;
    logic        eh;
    logic [3:0]  el;
    logic [1:0]  ep;
    logic [15:0] epd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{4'b0001, 16'h0005, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd0,  2'd0, 16'h0020},
    '{4'b0110, 16'h0290, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd0,  2'd0, 16'h0224},
    '{4'b0000, 16'h0000, 4'b0100, 1'b0, 4'b0100, 1'b1, 1'b1, 4'd9,  2'd2, 16'h0024},
    '{4'b0000, 16'h0000, 4'b1111, 1'b0, 4'b1000, 1'b1, 1'b1, 4'd5,  2'd3, 16'h0004},
    '{4'b0000, 16'h0000, 4'b1111, 1'b0, 4'b0001, 1'b1, 1'b1, 4'd2,  2'd0, 16'h0000},
    '{4'b0000, 16'h0000, 4'b1111, 1'b0, 4'b0010, 1'b1, 1'b0, 4'd0,  2'd1, 16'h0000},
    '{4'b1001, 16'hF00F, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd0,  2'd0, 16'h8000},
    '{4'b0110, 16'h00F0, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd0,  2'd0, 16'h8001},
    '{4'b0010, 16'h00F0, 4'b0010, 1'b0, 4'b0010, 1'b1, 1'b1, 4'd15, 2'd1, 16'h8001},
    '{4'b0000, 16'h0000, 4'b0001, 1'b1, 4'b0001, 1'b1, 1'b1, 4'd15, 2'd0, 16'hFFFF},
    '{4'b0000, 16'h0000, 4'b1100, 1'b0, 4'b0100, 1'b1, 1'b1, 4'd15, 2'd2, 16'h7FFF},
    '{4'b0000, 16'h0000, 4'b1000, 1'b0, 4'b1000, 1'b1, 1'b1, 4'd14, 2'd3, 16'h3FFF},
    '{4'b0000, 16'h0000, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd0,  2'd0, 16'h3FFF}
  };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    post_valid = '0; post_level = '0; fetch_req = '0; set_all = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pending in reset", 32'(pending), 32'h0);
    check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      post_valid = VT[i].pv;
      post_level = VT[i].plv;
      fetch_req  = VT[i].fr;
      set_all    = VT[i].sa;
      #1;
      check("R8/R9", $sformatf("grant v%0d", i), 32'(fetch_gnt), 32'(VT[i].eg));
      @(posedge clk);
      @(negedge clk);
      check("R3", $sformatf("rsp_valid v%0d", i), 32'(rsp_valid), 32'(VT[i].ev));
      if (VT[i].ev) begin
        check("R3/R5", $sformatf("rsp_hit v%0d", i), 32'(rsp_hit), 32'(VT[i].eh));
        check("R3/R11", $sformatf("rsp_level v%0d", i), 32'(rsp_level), 32'(VT[i].el));
        check("R10", $sformatf("rsp_port v%0d", i), 32'(rsp_port), 32'(VT[i].ep));
      end
      check("R2/R4/R6/R7", $sformatf("pending v%0d", i), 32'(pending), 32'(VT[i].epd));
      idle_inputs();
    end

    // R1 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #2;
    check("R1", "pending async clear", 32'(pending), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 then full drain in descending order (R4), ending on a miss (R5)
    set_all = 1'b1;
    @(negedge clk);
    set_all = 1'b0;
    check("R7", "set_all fills", 32'(pending), 32'hFFFF);
    for (int k = 15; k >= 0; k--) begin
      fetch_req = 4'b1000;
      @(posedge clk);
      @(negedge clk);
      check("R4", $sformatf("drain level k=%0d", k), 32'(rsp_level), 32'(k));
      check("R4", $sformatf("drain pending k=%0d", k), 32'(pending), 32'((32'h1 << k) - 1));
    end
    @(posedge clk);
    @(negedge clk);
    fetch_req = '0;
    check("R5", "miss after drain hit", 32'(rsp_hit), 32'h0);
    check("R5", "miss level", 32'(rsp_level), 32'h0);
    check("R5", "miss pending", 32'(pending), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule